// File: doc/BRIEF.md
# Error-Checked Router Input Channel

This block is the receiving half of one router port. Each cycle the link may present one coded flit: 32 data bits protected by a 39-bit single-error-correcting, double-error-detecting Hamming code. The channel decodes the flit and decides whether it may enter an eight-entry input queue. The flit enters only if it counts as error-free under the error-control mode chosen at elaboration, if the queue has room, and if the crossbar has granted the output port the flit is heading for. The crossbar reads the queue through a valid/ready interface.

Three modes are available. In plain mode, which covers both no code and forward correction only, every flit is accepted and single-bit errors are repaired. In detect mode any detected error rejects the flit. In hybrid mode single-bit errors are repaired and only uncorrectable errors reject the flit. In both retry modes every flit that is refused raises a one-cycle NACK toward the upstream go-back-N sender. The channel then discards later flits until the sender marks a replayed flit, so the queue stays in order. A bypass parameter removes the decoder: the payload is taken raw from the codeword and no error is ever flagged.

Top module: `ich_rx_channel`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `nack` and `err` are low.
- R2: Codeword layout: data bit k sits at the k-th position of `lnk_code` that is not a power of two, counting upward from position 3. Positions 1, 2, 4, 8, 16 and 32 each make even the XOR of all positions 1..38 whose index has that bit set. Position 0 makes the XOR of all 39 bits zero.
- R3: With MODE=0 (plain), `nack` and `err` never rise. A single-bit error is corrected. A double-bit error is stored with the data bits taken as received.
- R4: With MODE=1 (detect), a flit with any nonzero syndrome or odd overall parity is not stored, and `err` and `nack` are high in the cycle after it.
- R5: With MODE=2 (hybrid), a single-bit error is corrected and the flit is stored with no NACK. A double-bit error is not stored, and `err` and `nack` are high in the cycle after it.
- R6: A flit that arrives while `route_grant` is low is not stored. In the retry modes it raises `nack` one cycle later, with `err` low.
- R7: While the queue holds eight flits, an arriving flit is not decoded and not stored: `err` stays low, `nack` rises in the retry modes, and a read in the same cycle does not make room for it.
- R8: After a NACK the channel stores nothing and raises no NACK for flits without `lnk_retry`. The first flit with `lnk_retry` is judged normally. Outside recovery, `lnk_retry` has no effect.
- R9: The queue delivers flits in arrival order. `out_valid` rises the cycle after a write. `out_data` holds steady while `out_valid` is high and `out_ready` is low. The queue never holds more than eight flits.
- R10: With DECODE_EN=0, the stored payload is the raw data positions of R2 without correction, and `err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lnk_valid | input | 1 | A coded flit is present on the link this cycle |
| lnk_code | input | 39 | Coded flit, layout per R2 |
| lnk_retry | input | 1 | Marks a flit replayed after a NACK |
| route_grant | input | 1 | Target output port has been granted to this flit |
| nack | output | 1 | One-cycle request to replay from the refused flit |
| err | output | 1 | The refused flit carried an error the mode does not tolerate |
| out_valid | output | 1 | Queue head is valid |
| out_ready | input | 1 | Crossbar takes the queue head |
| out_data | output | 32 | Queue head payload |

## Verification
Two pairs of functions can coincide in one cycle. First, an uncorrectable flit can arrive while the queue is full. The bench fills the queue with eight clean flits, then sends a double-bit error and expects a NACK with `err` low, because no decode takes place. Second, a read can coincide with a write attempt on a full queue. The bench sends the replayed flit while raising `out_ready`. The write must still be refused and NACKed, and the drained order must show that only the head left.

// File: rtl/ich_pkg.sv
// Shared constants and code helpers for the router input channel.
// Assumes a 32-bit payload protected by a 39-bit SEC-DED Hamming code.
package ich_pkg;
    localparam int DW = 32;               // payload width
    localparam int CW = 39;               // codeword width
    localparam int SW = 6;                // syndrome width

    localparam int EC_PLAIN  = 0;         // accept everything
    localparam int EC_DETECT = 1;         // reject on any detected error
    localparam int EC_HYBRID = 2;         // correct single, reject double

    // Position in the codeword of payload bit k (non-powers of two from 3 up)
    function automatic int data_pos(input int k);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p < CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == k) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Build a codeword from a payload
    function automatic logic [CW-1:0] secded_encode(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        logic [SW-1:0] s;
        c = '0;
        for (int k = 0; k < DW; k++) c[data_pos(k)] = d[k];
        s = '0;
        for (int p = 1; p < CW; p++) if (c[p]) s ^= SW'(p);
        for (int i = 0; i < SW; i++) c[1 << i] = s[i];
        c[0] = ^c[CW-1:1];
        return c;
    endfunction
endpackage

// File: rtl/ich_secded_dec.sv
// Combinational SEC-DED decoder for one coded flit.
// Assumes the layout of ich_pkg. With DECODE_EN=0 the payload is
// extracted raw and both error flags are tied low.
module ich_secded_dec
    import ich_pkg::*;
#(
    parameter bit DECODE_EN = 1'b1
) (
    input  logic [CW-1:0] code,
    output logic [DW-1:0] data,
    output logic          any_err,
    output logic          multi_err
);
    generate
        if (DECODE_EN) begin : g_dec
            logic [SW-1:0] syn;
            logic          par;
            logic          single;
            logic [CW-1:0] fixed;

            // Syndrome, overall parity, single-bit repair and extraction
            always_comb begin
                syn = '0;
                par = 1'b0;
                for (int p = 0; p < CW; p++) begin
                    if (code[p]) begin
                        syn ^= SW'(p);
                        par ^= 1'b1;
                    end
                end
                single = par && (int'(syn) < CW);
                fixed  = code;
                if (single) fixed[syn] = ~code[syn];
                for (int k = 0; k < DW; k++) data[k] = fixed[data_pos(k)];
                any_err   = par || (syn != '0);
                multi_err = any_err && !single;
            end
        end else begin : g_bypass
            // Raw payload extraction, no error information
            always_comb begin
                for (int k = 0; k < DW; k++) data[k] = code[data_pos(k)];
                any_err   = 1'b0;
                multi_err = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/ich_admit.sv
// Admission control: decides per flit whether it is written, refused with
// NACK, or silently discarded during go-back-N recovery.
// Assumes the error flags are valid in the same cycle as flit_valid.
module ich_admit
    import ich_pkg::*;
#(
    parameter int MODE = EC_HYBRID
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flit_valid,
    input  logic flit_retry,
    input  logic grant,
    input  logic full,
    input  logic any_err,
    input  logic multi_err,
    output logic wr_en,
    output logic nack,
    output logic err
);
    localparam bit RETRY = (MODE != EC_PLAIN);

    logic recovering;
    logic bad;
    logic take;
    logic drop;
    logic nack_q;
    logic err_q;

    // Classify the current flit under the configured mode
    always_comb begin
        if (MODE == EC_DETECT)      bad = any_err;
        else if (MODE == EC_HYBRID) bad = multi_err;
        else                        bad = 1'b0;
        bad   = bad && !full;
        take  = flit_valid && (!recovering || flit_retry);
        wr_en = take && !full && grant && !bad;
        drop  = take && !wr_en;
    end

    // Register NACK/error pulses and track recovery after a refusal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recovering <= 1'b0;
            nack_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            nack_q <= drop && RETRY;
            err_q  <= take && bad;
            if (drop && RETRY)  recovering <= 1'b1;
            else if (wr_en)     recovering <= 1'b0;
        end
    end

    assign nack = nack_q;
    assign err  = err_q;
endmodule

// File: rtl/ich_flit_fifo.sv
// Input queue with a valid/ready read side.
// Assumes the writer never writes while full (enforced by admission).
module ich_flit_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic                       rd_ready,
    output logic                       rd_valid,
    output logic [WIDTH-1:0]           rd_data,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int AW = $clog2(DEPTH);
    localparam int FW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [FW-1:0]    cnt;
    logic             rd_en;

    assign rd_valid = (cnt != '0);
    assign full     = (cnt == FW'(DEPTH));
    assign rd_en    = rd_valid && rd_ready;
    assign rd_data  = mem[rptr];
    assign fill     = cnt;

    // Storage write, no reset needed for the data array
    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_data;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (wr_en) wptr <= (int'(wptr) == DEPTH - 1) ? '0 : wptr + 1'b1;
            if (rd_en) rptr <= (int'(rptr) == DEPTH - 1) ? '0 : rptr + 1'b1;
            cnt <= cnt + FW'(wr_en) - FW'(rd_en);
        end
    end
endmodule

// File: rtl/ich_rx_channel.sv
// Router input channel: decode, admit and queue coded flits; NACK refusals.
// Assumes one flit per cycle at most and a go-back-N sender upstream that
// marks the first replayed flit with lnk_retry.
module ich_rx_channel
    import ich_pkg::*;
#(
    parameter int MODE      = EC_HYBRID,
    parameter bit DECODE_EN = 1'b1,
    parameter int DEPTH     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lnk_valid,
    input  logic [CW-1:0] lnk_code,
    input  logic          lnk_retry,
    input  logic          route_grant,
    output logic          nack,
    output logic          err,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    localparam int FW = $clog2(DEPTH + 1);

    logic [DW-1:0] dec_data;
    logic          any_err;
    logic          multi_err;
    logic          wr_en;
    logic          fifo_full;
    logic [FW-1:0] fill;

    ich_secded_dec #(.DECODE_EN(DECODE_EN)) u_dec (
        .code      (lnk_code),
        .data      (dec_data),
        .any_err   (any_err),
        .multi_err (multi_err)
    );

    ich_admit #(.MODE(MODE)) u_admit (
        .clk        (clk),
        .rst_n      (rst_n),
        .flit_valid (lnk_valid),
        .flit_retry (lnk_retry),
        .grant      (route_grant),
        .full       (fifo_full),
        .any_err    (any_err),
        .multi_err  (multi_err),
        .wr_en      (wr_en),
        .nack       (nack),
        .err        (err)
    );

    ich_flit_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (dec_data),
        .rd_ready (out_ready),
        .rd_valid (out_valid),
        .rd_data  (out_data),
        .full     (fifo_full),
        .fill     (fill)
    );
endmodule

// File: rtl/ich_rx_channel_chk.sv
// Property checker for ich_rx_channel, attached by bind below.
module ich_rx_channel_chk #(
    parameter int MODE  = 2,
    parameter int DEPTH = 8,
    parameter int FW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          nack,
    input logic          err,
    input logic          out_valid,
    input logic          out_ready,
    input logic [31:0]   out_data,
    input logic          wr_en,
    input logic          fifo_full,
    input logic [FW-1:0] fill
);
    // R7: nothing is written into a full queue
    a_r7_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !wr_en);

    // R9: occupancy never exceeds the depth
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill) <= DEPTH);

    // R9: head held while stalled
    a_r9_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R3: plain mode never requests a replay
    a_r3_plain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == 0) |-> (!nack && !err));

    // R4/R5: a flagged error always comes with a replay request
    a_r5_err_with_nack: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> nack);

    // R9: a write shows up as a valid head on the next cycle
    a_r9_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> out_valid);
endmodule

bind ich_rx_channel ich_rx_channel_chk #(.MODE(MODE), .DEPTH(DEPTH), .FW(FW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .nack      (nack),
    .err       (err),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .wr_en     (wr_en),
    .fifo_full (fifo_full),
    .fill      (fill)
);

// File: tb/sim_ich_rx_channel.sv
// Directed bench: four channels share one link; u0 hybrid, u1 detect,
// u2 plain, u3 hybrid with the decoder bypassed.
module sim_ich_rx_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lnk_valid = 1'b0;
    logic [38:0] lnk_code = '0;
    logic        lnk_retry = 1'b0;
    logic        route_grant = 1'b1;
    logic [3:0]  rdy = '0;
    logic [3:0]  nk;
    logic [3:0]  er;
    logic [3:0]  ov;
    logic [31:0] od [4];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    ich_rx_channel #(.MODE(2), .DECODE_EN(1'b1)) u0 (.clk(clk), .rst_n(rst_n),
        .lnk_valid(lnk_valid), .lnk_code(lnk_code), .lnk_retry(lnk_retry),
        .route_grant(route_grant), .nack(nk[0]), .err(er[0]), .out_valid(ov[0]),
        .out_ready(rdy[0]), .out_data(od[0]));
    ich_rx_channel #(.MODE(1), .DECODE_EN(1'b1)) u1 (.clk(clk), .rst_n(rst_n),
        .lnk_valid(lnk_valid), .lnk_code(lnk_code), .lnk_retry(lnk_retry),
        .route_grant(route_grant), .nack(nk[1]), .err(er[1]), .out_valid(ov[1]),
        .out_ready(rdy[1]), .out_data(od[1]));
    ich_rx_channel #(.MODE(0), .DECODE_EN(1'b1)) u2 (.clk(clk), .rst_n(rst_n),
        .lnk_valid(lnk_valid), .lnk_code(lnk_code), .lnk_retry(lnk_retry),
        .route_grant(route_grant), .nack(nk[2]), .err(er[2]), .out_valid(ov[2]),
        .out_ready(rdy[2]), .out_data(od[2]));
    ich_rx_channel #(.MODE(2), .DECODE_EN(1'b0)) u3 (.clk(clk), .rst_n(rst_n),
        .lnk_valid(lnk_valid), .lnk_code(lnk_code), .lnk_retry(lnk_retry),
        .route_grant(route_grant), .nack(nk[3]), .err(er[3]), .out_valid(ov[3]),
        .out_ready(rdy[3]), .out_data(od[3]));

    // Bench-side encoder written from the R2 layout
    function automatic logic [38:0] enc(input logic [31:0] d);
        logic [38:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 3; p < 39; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < 6; b++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < 39; p++) if (p[b] && p != (1 << b)) x ^= c[p];
            c[1 << b] = x;
        end
        c[0] = ^c[38:1];
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one flit at a falling edge; check nack/err after the next rise
    task automatic send(input string req, input logic [38:0] code, input logic retry,
                        input logic [3:0] exp_nk, input logic [3:0] exp_er);
        lnk_valid = 1'b1;
        lnk_code  = code;
        lnk_retry = retry;
        @(posedge clk);
        @(negedge clk);
        lnk_valid = 1'b0;
        lnk_retry = 1'b0;
        chk({req, " nack"}, 32'(nk), 32'(exp_nk));
        chk({req, " err"}, 32'(er), 32'(exp_er));
    endtask

    // Check and pop the head of one channel
    task automatic pop(input string req, input int i, input logic [31:0] exp);
        chk({req, " valid"}, 32'(ov[i]), 32'd1);
        chk({req, " data"}, od[i], exp);
        rdy[i] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rdy[i] = 1'b0;
    endtask

    task automatic empty_all(input string req);
        chk({req, " empty"}, 32'(ov), 32'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid", 32'(ov), 32'd0);
        chk("R1 nack", 32'(nk), 32'd0);
        chk("R1 err", 32'(er), 32'd0);
    endtask

    task automatic t_clean();
        send("R2 clean", enc(32'hA5A5_0001), 1'b0, 4'b0000, 4'b0000);
        for (int i = 0; i < 4; i++) pop("R2 clean", i, 32'hA5A5_0001);
        empty_all("R9 after clean");
    endtask

    task automatic t_single();
        logic [31:0] d2;
        logic [31:0] d3;
        d2 = 32'h1234_5678;
        d3 = 32'hCAFE_0003;
        // flip position 5 = data bit 1
        send("R5/R4 single", enc(d2) ^ (39'd1 << 5), 1'b0, 4'b0010, 4'b0010);
        send("R8 drop", enc(d3), 1'b0, 4'b0000, 4'b0000);
        send("R8 replay", enc(d2), 1'b1, 4'b0000, 4'b0000);
        pop("R5 corrected", 0, d2); pop("R5", 0, d3); pop("R8 retry ignored", 0, d2);
        pop("R8 replay accepted", 1, d2);
        pop("R3 corrected", 2, d2); pop("R3", 2, d3); pop("R3", 2, d2);
        pop("R10 raw", 3, d2 ^ 32'h2); pop("R10", 3, d3); pop("R10", 3, d2);
        empty_all("R8 after single");
    endtask

    task automatic t_double();
        logic [31:0] d4;
        d4 = 32'h0F0F_7777;
        send("R5/R4 double", enc(d4) ^ (39'd1 << 3) ^ (39'd1 << 5), 1'b0, 4'b0011, 4'b0011);
        send("R8 replay double", enc(d4), 1'b1, 4'b0000, 4'b0000);
        pop("R5 replay", 0, d4);
        pop("R4 replay", 1, d4);
        pop("R3 double raw", 2, d4 ^ 32'h3); pop("R3", 2, d4);
        pop("R10 double raw", 3, d4 ^ 32'h3); pop("R10", 3, d4);
        empty_all("R3 after double");
    endtask

    task automatic t_grant();
        logic [31:0] d5;
        d5 = 32'h5555_AAAA;
        route_grant = 1'b0;
        send("R6 no grant", enc(d5), 1'b0, 4'b1011, 4'b0000);
        route_grant = 1'b1;
        empty_all("R6 not stored");
        send("R6 replay", enc(d5), 1'b1, 4'b0000, 4'b0000);
        for (int i = 0; i < 4; i++) pop("R6 replay", i, d5);
        empty_all("R6 after");
    endtask

    task automatic t_full();
        for (int j = 0; j < 8; j++)
            send("R9 fill", enc(32'hF000_0000 + 32'(j)), 1'b0, 4'b0000, 4'b0000);
        send("R7 full+double", enc(32'hDEAD_0009) ^ 39'h18, 1'b0, 4'b1011, 4'b0000);
        rdy = 4'b1111;
        send("R7 full+read", enc(32'hF000_0008), 1'b1, 4'b1011, 4'b0000);
        rdy = 4'b0000;
        for (int i = 0; i < 4; i++)
            for (int j = 1; j < 8; j++) pop("R9 order", i, 32'hF000_0000 + 32'(j));
        empty_all("R7 nothing added");
        send("R7 replay after drain", enc(32'hF000_0008), 1'b1, 4'b0000, 4'b0000);
        for (int i = 0; i < 4; i++) pop("R7 replay", i, 32'hF000_0008);
        empty_all("R9 final");
    endtask

    initial begin
        t_reset();
        t_clean();
        t_single();
        t_double();
        t_grant();
        t_full();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule